// File: doc/BRIEF.md
# Power-of-Two Programmable Clock Divider

This block derives a gated output clock from a free-running reference clock. Software programs it through a byte-wide register port: one register holds a 3-bit divide code, another holds a single run bit. Codes 2 to 7 divide the reference by 2, 4, 8, 16, 32 or 64 with a 50% duty cycle. Codes 0 and 1 both pass the reference clock straight through, gated.

The register port runs on its own bus clock. The run bit reaches the reference domain through a two-flop synchronizer. The output only starts or stops while it is low, so the output never shows a shortened high pulse. The divide code is sampled once, when the output starts. A new code written while the output runs is stored and read back, but it only takes effect at the next start.

To change the ratio, software clears the run bit, waits for the stop latency, writes the new code, and sets the run bit again. One reset input serves both domains. The block synchronizes that reset separately into the bus domain and into the reference domain.

Top module: `pow2_clk_divider`

## Requirements
- R1: After reset the run bit and the divide code both read as 0, and `clk_out` stays low.
- R2: The divide code is held in bits [2:0] of the register at offset 0x43. It reads back as written, and bits [7:3] read as 0. Read data appears on `reg_rdata` after the bus clock edge that samples `reg_rd`.
- R3: The run bit is bit 7 of the register at offset 0x46. It reads back as written, and bits [6:0] read as 0.
- R4: A read at any offset other than 0x43 or 0x46 returns 0. A write there changes neither register.
- R5: With a latched code c from 2 to 7, `clk_out` has a period of 2^(c-1) reference periods and stays high for exactly half of that.
- R6: With a latched code of 0 or 1, `clk_out` follows the reference clock (period 1, high for half a period) while running.
- R7: Let D be the divide ratio. After the bus write that sets the run bit, the first rising edge of `clk_out` comes within (2 + 3·D) reference periods.
- R8: Let D be the divide ratio. Within 3·D reference periods of the bus write that clears the run bit, `clk_out` is low and no further rising edges follow. The last high pulse has full length.
- R9: A code written while the output runs changes neither the period nor the duty cycle until the run bit is cleared and set again. After that, the new code applies.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bus_clk | input | 1 | Clock of the register port |
| ref_clk | input | 1 | Reference clock that is divided |
| rst_ni | input | 1 | Asynchronous active-low reset, synchronized per domain |
| reg_addr | input | 8 | Register offset inside the block's window |
| reg_wdata | input | 8 | Write data |
| reg_wr | input | 1 | Write strobe, one bus cycle per write |
| reg_rd | input | 1 | Read strobe, one bus cycle per read |
| reg_rdata | output | 8 | Registered read data |
| clk_out | output | 1 | Gated, divided output clock |

## Verification
The assertions assume that the divide code does not change in the reference-clock cycles around a start. In other words, software writes the code in an earlier bus cycle than the one that sets the run bit, and it keeps the run bit stable for several reference cycles after each change. The stimulus always writes the code first and sets the run bit in a separate, later write. It waits out the full stop latency before the next start. The only code writes made while the output runs are deliberate ones, used to check that such writes are deferred. The bus clock and the reference clock are offset so that their edges never coincide.

// File: rtl/pow2div_pkg.sv
`timescale 1ns/1ps
package pow2div_pkg;

  // Minimum depth of a synchronizer chain
  localparam int unsigned SYNC_MIN = 2;

  // Run state of the output clock
  typedef enum logic {
    OUT_IDLE   = 1'b0,
    OUT_ACTIVE = 1'b1
  } out_state_e;

endpackage

// File: rtl/pow2div_sync.sv
`timescale 1ns/1ps
module pow2div_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  localparam int unsigned N = (STAGES < pow2div_pkg::SYNC_MIN) ? pow2div_pkg::SYNC_MIN : STAGES;

  logic [N-1:0] sh_q;
  logic [N-1:0] sh_d;

  always_comb begin
    sh_d = {sh_q[N-2:0], d};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign q = sh_q[N-1];
endmodule

// File: rtl/pow2div_regs.sv
`timescale 1ns/1ps
module pow2div_regs #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned CODE_W = 3,
  parameter int unsigned EN_BIT = 7,
  parameter logic [ADDR_W-1:0] DIV_OFS = 'h43,
  parameter logic [ADDR_W-1:0] EN_OFS  = 'h46
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              wr_en,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rdata,
  output logic              en_q,
  output logic [CODE_W-1:0] code_q
);
  logic              en_d;
  logic [CODE_W-1:0] code_d;
  logic [DATA_W-1:0] rd_d;
  logic [DATA_W-1:0] rd_q;
  logic              hit_div;
  logic              hit_en;

  always_comb begin
    hit_div = (addr == DIV_OFS);
    hit_en  = (addr == EN_OFS);
    en_d    = en_q;
    code_d  = code_q;
    if (wr_en && hit_en)  en_d   = wdata[EN_BIT];
    if (wr_en && hit_div) code_d = wdata[CODE_W-1:0];
    rd_d = '0;
    if (hit_div)     rd_d[CODE_W-1:0] = code_q;
    else if (hit_en) rd_d[EN_BIT]     = en_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      code_q <= '0;
    end else begin
      en_q   <= en_d;
      code_q <= code_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rd_q <= '0;
    else if (rd_en) rd_q <= rd_d;
  end

  assign rdata = rd_q;

  p_run_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == EN_OFS) |=> (en_q == $past(wdata[EN_BIT])));

  p_code_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == DIV_OFS) |=> (code_q == $past(wdata[CODE_W-1:0])));

  p_unmapped_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr != DIV_OFS && addr != EN_OFS) |=> (rdata == '0));

  p_unmapped_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr != DIV_OFS && addr != EN_OFS) |=> ($stable(en_q) && $stable(code_q)));
endmodule

// File: rtl/pow2div_core.sv
`timescale 1ns/1ps
module pow2div_core #(
  parameter int unsigned CODE_W = 3
) (
  input  logic              ref_clk,
  input  logic              rst_n,
  input  logic              en_s,
  input  logic [CODE_W-1:0] code_i,
  output logic              clk_o
);
  import pow2div_pkg::*;

  localparam int unsigned MAX_CODE = (1 << CODE_W) - 1;
  localparam int unsigned MAX_DIV  = 1 << (MAX_CODE - 1);
  localparam int unsigned CNT_W    = (MAX_DIV > 2) ? $clog2(MAX_DIV / 2) : 1;
  localparam int unsigned HI_W     = CNT_W + 1;

  out_state_e        st_q, st_d;
  logic [CODE_W-1:0] act_q, act_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              div_q, div_d;
  logic [CNT_W-1:0]  lim;
  logic              bypass;
  logic              gate_q, gate_d;
  logic [HI_W-1:0]   hi_len;

  always_comb begin
    bypass = (act_q <= CODE_W'(1));
    lim    = '0;
    if (!bypass) lim = CNT_W'((32'd1 << (32'(act_q) - 32'd2)) - 32'd1);
  end

  always_comb begin
    st_d  = st_q;
    act_d = act_q;
    cnt_d = cnt_q;
    div_d = div_q;
    case (st_q)
      OUT_IDLE: begin
        cnt_d = '0;
        div_d = 1'b0;
        if (en_s) begin
          st_d  = OUT_ACTIVE;
          act_d = code_i;
        end
      end
      default: begin
        if (bypass) begin
          if (!en_s) st_d = OUT_IDLE;
        end else begin
          if (cnt_q == lim) begin
            cnt_d = '0;
            div_d = ~div_q;
          end else begin
            cnt_d = cnt_q + CNT_W'(1);
          end
          if (!en_s && !div_d) begin
            st_d  = OUT_IDLE;
            cnt_d = '0;
          end
        end
      end
    endcase
  end

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= OUT_IDLE;
      act_q <= '0;
      cnt_q <= '0;
      div_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      act_q <= act_d;
      cnt_q <= cnt_d;
      div_q <= div_d;
    end
  end

  // Pass-through gate: updated on the falling edge, while ref_clk is low
  always_comb gate_d = en_s && (st_q == OUT_ACTIVE) && bypass;

  always_ff @(negedge ref_clk or negedge rst_n) begin
    if (!rst_n) gate_q <= 1'b0;
    else        gate_q <= gate_d;
  end

  assign clk_o = bypass ? (ref_clk & gate_q) : div_q;

  // Length of the current high phase of the divided clock, in reference cycles
  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n)     hi_len <= '0;
    else if (div_q) hi_len <= hi_len + HI_W'(1);
    else            hi_len <= '0;
  end

  p_full_high_r5: assert property (@(posedge ref_clk) disable iff (!rst_n)
    $fell(div_q) |-> (hi_len == (HI_W'(MAX_DIV / 2) >> (MAX_CODE - 32'(act_q)))));

  p_code_held_r9: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (st_q == OUT_ACTIVE && $past(st_q) == OUT_ACTIVE) |-> $stable(act_q));

  p_idle_low_r8: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (st_q == OUT_IDLE) |-> !div_q);

  p_bypass_quiet_r6: assert property (@(posedge ref_clk) disable iff (!rst_n)
    bypass |-> !div_q);
endmodule

// File: rtl/pow2_clk_divider.sv
`timescale 1ns/1ps
module pow2_clk_divider #(
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned CODE_W      = 3,
  parameter int unsigned EN_BIT      = 7,
  parameter logic [ADDR_W-1:0] DIV_OFS = 'h43,
  parameter logic [ADDR_W-1:0] EN_OFS  = 'h46,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              bus_clk,
  input  logic              ref_clk,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic              reg_wr,
  input  logic              reg_rd,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              clk_out
);
  logic              bus_rst_n;
  logic              ref_rst_n;
  logic              en_q;
  logic              en_s;
  logic [CODE_W-1:0] code_q;

  pow2div_sync #(.STAGES(SYNC_STAGES)) u_bus_rst (
    .clk(bus_clk), .rst_n(rst_ni), .d(1'b1), .q(bus_rst_n));

  pow2div_sync #(.STAGES(SYNC_STAGES)) u_ref_rst (
    .clk(ref_clk), .rst_n(rst_ni), .d(1'b1), .q(ref_rst_n));

  pow2div_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CODE_W(CODE_W), .EN_BIT(EN_BIT),
    .DIV_OFS(DIV_OFS), .EN_OFS(EN_OFS)
  ) u_regs (
    .clk(bus_clk), .rst_n(bus_rst_n), .addr(reg_addr), .wdata(reg_wdata),
    .wr_en(reg_wr), .rd_en(reg_rd), .rdata(reg_rdata),
    .en_q(en_q), .code_q(code_q));

  pow2div_sync #(.STAGES(SYNC_STAGES)) u_en_sync (
    .clk(ref_clk), .rst_n(ref_rst_n), .d(en_q), .q(en_s));

  pow2div_core #(.CODE_W(CODE_W)) u_core (
    .ref_clk(ref_clk), .rst_n(ref_rst_n), .en_s(en_s),
    .code_i(code_q), .clk_o(clk_out));
endmodule

// File: tb/pow2_clk_divider_test.sv
`timescale 1ns/1ps
module pow2_clk_divider_test;
  localparam logic [7:0] A_DIV = 8'h43;
  localparam logic [7:0] A_EN  = 8'h46;
  localparam longint TREF = 4;

  logic       bus_clk, ref_clk, rst_ni;
  logic [7:0] reg_addr, reg_wdata, reg_rdata;
  logic       reg_wr, reg_rd;
  logic       clk_out;

  int  n_vec = 0;
  int  n_bad = 0;
  int  rise_cnt = 0;
  time last_rise = 0;
  time last_fall = 0;
  time t_wr = 0;

  pow2_clk_divider uut (
    .bus_clk(bus_clk), .ref_clk(ref_clk), .rst_ni(rst_ni),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .reg_rdata(reg_rdata), .clk_out(clk_out));

  // 250 MHz reference; bus edges at 10n+5 never meet reference edges at 4k+2
  initial ref_clk = 1'b0;
  always #2 ref_clk = ~ref_clk;
  initial bus_clk = 1'b0;
  always #5 bus_clk = ~bus_clk;

  always @(posedge clk_out) begin
    last_rise = $time;
    rise_cnt  = rise_cnt + 1;
  end
  always @(negedge clk_out) last_fall = $time;

  function automatic longint ratio_of(input int code);
    return (code <= 1) ? 1 : (longint'(1) << (code - 1));
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [7:0] d);
    @(negedge bus_clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(posedge bus_clk);
    t_wr = $time;
    #1 reg_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [7:0] d);
    @(negedge bus_clk);
    reg_addr = a; reg_rd = 1'b1;
    @(posedge bus_clk);
    #1 reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  // Start the output and check start latency, period and high time
  task automatic start_and_measure(input longint d_exp, input string req_shape);
    time t0, r1, f1, r2;
    int  n0;
    longint bound;
    bus_write(A_EN, 8'h80);
    t0 = t_wr;
    n0 = rise_cnt;
    bound = (2 + 3 * d_exp) * TREF;
    while (rise_cnt == n0 && longint'($time - t0) <= bound) #1;
    check(rise_cnt != n0 && longint'(last_rise - t0) <= bound, "R7",
          "first rise delay ns", longint'(last_rise - t0), bound);
    @(posedge clk_out); r1 = $time;
    @(negedge clk_out); f1 = $time;
    @(posedge clk_out); r2 = $time;
    check(longint'(r2 - r1) == d_exp * TREF, req_shape, "period ns",
          longint'(r2 - r1), d_exp * TREF);
    check(longint'(f1 - r1) == d_exp * TREF / 2, req_shape, "high ns",
          longint'(f1 - r1), d_exp * TREF / 2);
  endtask

  task automatic stop_and_check(input longint d_exp);
    int n1;
    bus_write(A_EN, 8'h00);
    #(3 * d_exp * TREF);
    n1 = rise_cnt;
    check(clk_out == 1'b0, "R8", "level at stop bound", longint'(clk_out), 0);
    check(longint'(last_fall - last_rise) == d_exp * TREF / 2, "R8",
          "last pulse ns", longint'(last_fall - last_rise), d_exp * TREF / 2);
    #(8 * d_exp * TREF + 40);
    check(rise_cnt == n1 && clk_out == 1'b0, "R8", "edges after stop",
          longint'(rise_cnt - n1), 0);
  endtask

  initial begin
    #600000;
    n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] rd;
    void'($urandom(32'h5eed_0421));
    reg_addr = '0; reg_wdata = '0; reg_wr = 1'b0; reg_rd = 1'b0;
    rst_ni = 1'b0;
    #23;
    check(clk_out == 1'b0, "R1", "clk_out in reset", longint'(clk_out), 0);
    #30 rst_ni = 1'b1;
    repeat (4) @(posedge bus_clk);

    // R1 reset state
    bus_read(A_DIV, rd); check(rd == 8'h00, "R1", "code after reset", rd, 0);
    bus_read(A_EN, rd);  check(rd == 8'h00, "R1", "run after reset", rd, 0);
    check(rise_cnt == 0, "R1", "edges after reset", rise_cnt, 0);

    // R2 and R3 read-back with unused bits cleared
    bus_write(A_DIV, 8'hfd);
    bus_read(A_DIV, rd); check(rd == 8'h05, "R2", "code readback", rd, 8'h05);
    bus_write(A_DIV, 8'h00);
    bus_write(A_EN, 8'h7f);
    bus_read(A_EN, rd);  check(rd == 8'h00, "R3", "run low bits", rd, 0);
    #100 check(rise_cnt == 0, "R3", "no start from low bits", rise_cnt, 0);

    // R6 directed: code 0 and code 1 both pass the reference
    start_and_measure(1, "R6");
    stop_and_check(1);
    bus_write(A_DIV, 8'h01);
    start_and_measure(1, "R6");
    stop_and_check(1);

    // R5 directed extremes: divide by 2 and by 64
    bus_write(A_DIV, 8'h02);
    start_and_measure(2, "R5");
    stop_and_check(2);
    bus_write(A_DIV, 8'h07);
    start_and_measure(64, "R5");
    stop_and_check(64);

    // R9 deferred code change
    bus_write(A_DIV, 8'h03);
    start_and_measure(4, "R9");
    bus_write(A_DIV, 8'hff);
    bus_read(A_DIV, rd); check(rd == 8'h07, "R9", "code stored while running", rd, 7);
    begin
      time ra, rb;
      @(posedge clk_out); ra = $time;
      @(posedge clk_out); rb = $time;
      check(longint'(rb - ra) == 4 * TREF, "R9", "period kept", longint'(rb - ra), 4 * TREF);
    end
    stop_and_check(4);
    start_and_measure(64, "R9");
    stop_and_check(64);

    // Random mix of codes and unmapped accesses
    for (int i = 0; i < 14; i++) begin
      int code;
      logic [7:0] junk, ua;
      code = int'($urandom % 8);
      junk = 8'($urandom);
      bus_write(A_DIV, {junk[7:3], 3'(code)});
      bus_read(A_DIV, rd);
      check(rd == 8'(code), "R2", "random code readback", rd, code);
      ua = 8'($urandom);
      if (ua == A_DIV || ua == A_EN) ua = ua + 8'd1;
      bus_write(ua, 8'hff);
      bus_read(ua, rd);   check(rd == 8'h00, "R4", "unmapped read", rd, 0);
      bus_read(A_DIV, rd); check(rd == 8'(code), "R4", "code after unmapped write", rd, code);
      bus_read(A_EN, rd);  check(rd == 8'h00, "R4", "run after unmapped write", rd, 0);
      start_and_measure(ratio_of(code), (code <= 1) ? "R6" : "R5");
      bus_read(A_EN, rd);  check(rd == 8'h80, "R3", "run readback", rd, 8'h80);
      stop_and_check(ratio_of(code));
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule